// File: doc/BRIEF.md
# Serial Peripheral Port with Status Flags

This block is a byte-wide SPI port that a processor drives through three small registers: a data register, a status register and a control register. It acts either as the clock-generating master or as a slave clocked from outside. Writing the data register starts an exchange of one byte, most significant bit first. Data is captured on the rising SCK edge and the next bit is put out on the falling edge, with SCK idling low. Reading the data register returns the last fully received byte. It never returns the byte in flight.

Status bit 7 is the completion flag. Bit 6 is the collision flag. Bit 0 selects double-speed master clocking. A completion flag can also come from a mode fault: the select pin is pulled low while the port is master. The fault returns the port to slave mode and cancels any exchange in progress. The flags clear in two ways. One is a status read that sees them set, followed by any access to the data register. The other, for the completion flag only, is an interrupt acknowledge pulse.

The control register sits at register address 2:
- bit 0 enables the port.
- bit 1 selects master mode.
- bit 2 enables the interrupt.
- bits 4:3 select the clock rate.

The data register is at address 0 and the status register at address 1.

Top module: `spi_port`

## Requirements
- R1: After reset the status, control and data registers read 0x00, `sck_o` is low, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: In master mode (control 0x07 family), a data write while idle sends the written byte MSB first on `mosi_o`. Bits go out on falling SCK edges and `miso_i` is sampled on rising edges. The received byte is readable at address 0. During the exchange, address 0 still returns the previous received byte.
- R3: In master mode the SCK period is 4, 16, 64 or 128 system clocks for rate code 0, 1, 2 or 3. Status bit 0 halves it, down to a minimum of 2 clocks. The completion flag sets exactly 8 SCK periods after the clock edge that accepts the data write.
- R4: Status bit 7 sets when an exchange ends. `irq` is high whenever bit 7 is set and control bit 2 is set.
- R5: A data write while an exchange is in progress sets status bit 6. The written byte is discarded and the ongoing byte is sent unchanged.
- R6: The flags clear only when a status read that saw them set is followed by a read or write of address 0. An address-0 access with no such preceding status read leaves them set.
- R7: A one-cycle pulse on `irq_ack` clears status bit 7.
- R8: When `ss_n_i` goes low while the port is enabled as master, status bit 7 sets and control bit 1 clears. SCK stops and `sck_oe` drops within 4 cycles.
- R9: Status bits 5 to 1 always read zero, and status bit 0 reads back what was written.
- R10: In slave mode (control bit 1 clear) with `ss_n_i` low, the port shifts on `sck_i` with the same edge rules. It drives the preloaded byte MSB first on `miso_o` and receives the byte on `mosi_i`. `miso_oe` is high only while `ss_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_addr | input | 2 | register select: 0 data, 1 status, 2 control |
| reg_rd | input | 1 | register read strobe |
| reg_wr | input | 1 | register write strobe |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data for the selected register |
| irq | output | 1 | interrupt request |
| irq_ack | input | 1 | interrupt acknowledge, clears completion flag |
| sck_i | input | 1 | serial clock in (slave) |
| sck_o | output | 1 | serial clock out (master) |
| sck_oe | output | 1 | serial clock output enable |
| mosi_i | input | 1 | serial data in (slave) |
| mosi_o | output | 1 | serial data out (master) |
| mosi_oe | output | 1 | master data output enable |
| miso_i | input | 1 | serial data in (master) |
| miso_o | output | 1 | serial data out (slave) |
| miso_oe | output | 1 | slave data output enable |
| ss_n_i | input | 1 | active-low select |

## Verification
The master path is run with 0xA5/0x3C, 0x81/0xE7 and other asymmetric byte pairs, so that a reversed bit order or a one-bit slip shows up on both lines. It is run at four rate and double-speed combinations, where the measured cycle count separates the divider choices and the halving. The collision case writes 0xFF mid-byte, so leaking the discarded value changes the sent byte. The clear sequence is tried both with and without a preceding status read, which tells a proper two-step clear from a plain clear-on-access. The slave path is run with 0x96 preloaded and 0x5A on the input.

// File: rtl/spi_port_pkg.sv
// Shared register encodings for the SPI port.
// Assumes an 8-bit register interface with a 2-bit register select.
package spi_port_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] spare;
        logic [1:0] rate;
        logic       irq_en;
        logic       master;
        logic       on;
    } ctrl_t;
endpackage

// File: rtl/spi_rate_gen.sv
// Half-period timer for the master serial clock.
// Emits one tick per SCK half period while run is high; the half period is
// HALF_MAX>>5, >>3, >>1 or HALF_MAX clocks for rate 0..3, halved by dbl.
// Assumes HALF_MAX is a power of two of at least 64.
module spi_rate_gen #(
    parameter int HALF_MAX = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       dbl,
    output logic       tick
);
    localparam int CW = $clog2(HALF_MAX) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_len;
    logic [CW-1:0] last;

    // Pick the half-period length from rate and double-speed.
    always_comb begin
        case (rate)
            2'd0:    half_len = CW'(HALF_MAX >> 5);
            2'd1:    half_len = CW'(HALF_MAX >> 3);
            2'd2:    half_len = CW'(HALF_MAX >> 1);
            default: half_len = CW'(HALF_MAX);
        endcase
        if (dbl) half_len = half_len >> 1;
        last = half_len - 1'b1;
    end

    assign tick = run && (cnt == last);

    // Count clocks within a half period; restart on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Shared shift core for master and slave modes.
// Samples sdi on rise, shifts MSB first on fall, and flags done on the
// falling edge that completes W bits. A load has priority over abort;
// abort only resets the bit count.
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         abort,
    input  logic         rise,
    input  logic         fall,
    input  logic         sdi,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_next
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  sh;
    logic          samp;
    logic [BW-1:0] cnt;

    // Shift register, sampled bit and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            samp <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            sh  <= load_data;
            cnt <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else begin
            if (rise) samp <= sdi;
            if (fall) begin
                sh  <= {sh[W-2:0], samp};
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign sdo     = sh[W-1];
    assign rx_next = {sh[W-2:0], samp};
    assign done    = fall && !load && !abort && (cnt == BW'(W - 1));
endmodule

// File: rtl/spi_regs.sv
// Register file: data, status and control, plus flag set/clear rules.
// Flags clear by a status read that saw them set followed by a data access;
// irq_ack clears the completion flag. A mode fault clears the master bit.
module spi_regs
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        busy,
    input  logic        done,
    input  logic        modf,
    input  logic [7:0]  rx_byte,
    input  logic        irq_ack,
    output ctrl_t       ctrl,
    output logic        dbl,
    output logic        start,
    output logic        irq
);
    logic [7:0] rxbuf;
    logic       spif, wcol;
    logic       arm_f, arm_w;
    logic       data_acc, data_wr, stat_rd, stat_wr, ctrl_wr, coll;

    assign data_acc = (rd_en || wr_en) && (addr == REG_DATA);
    assign data_wr  = wr_en && (addr == REG_DATA);
    assign stat_rd  = rd_en && (addr == REG_STAT);
    assign stat_wr  = wr_en && (addr == REG_STAT);
    assign ctrl_wr  = wr_en && (addr == REG_CTRL);
    assign coll     = data_wr && busy;
    assign start    = data_wr && !busy && ctrl.on;
    assign irq      = spif && ctrl.irq_en;

    // Read multiplexer.
    always_comb begin
        case (reg_sel_e'(addr))
            REG_DATA: rdata = rxbuf;
            REG_STAT: rdata = {spif, wcol, 5'b0, dbl};
            REG_CTRL: rdata = ctrl;
            default:  rdata = 8'h00;
        endcase
    end

    // Control register; a mode fault drops master mode.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else begin
            if (ctrl_wr) ctrl <= ctrl_t'({3'b000, wdata[4:0]});
            if (modf)    ctrl.master <= 1'b0;
        end
    end

    // Double-speed bit and receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl   <= 1'b0;
            rxbuf <= '0;
        end else begin
            if (stat_wr) dbl   <= wdata[0];
            if (done)    rxbuf <= rx_byte;
        end
    end

    // Arm the clear sequence on a status read, consume it on a data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_f <= 1'b0;
            arm_w <= 1'b0;
        end else if (stat_rd) begin
            arm_f <= spif;
            arm_w <= wcol;
        end else if (data_acc) begin
            arm_f <= 1'b0;
            arm_w <= 1'b0;
        end
    end

    // Completion and collision flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif <= 1'b0;
            wcol <= 1'b0;
        end else begin
            if (done || modf)            spif <= 1'b1;
            else if (irq_ack)            spif <= 1'b0;
            else if (data_acc && arm_f)  spif <= 1'b0;
            if (coll)                    wcol <= 1'b1;
            else if (data_acc && arm_w)  wcol <= 1'b0;
        end
    end

    // R8
    modf_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        modf |=> !ctrl.master);
    // R4
    spif_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif) |-> $past(done || modf));
    // R5
    wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(data_wr && busy));
    // R6
    wcol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wcol) |-> $past(data_acc));
endmodule

// File: rtl/spi_port.sv
// Top of the SPI port: master clock generation, slave input synchronisers,
// mode-fault detection and pin enables around the shared shift engine.
// Assumes sck_i at most a quarter of clk in slave mode.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int HALF_MAX = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       irq_ack,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);
    localparam int SYNC_N = 2;

    ctrl_t       ctrl;
    logic        dbl, start, done, busy, modf, tick;
    logic        is_m, is_s, stop_m;
    logic        m_busy, sck_q, sck_p;
    logic        sck_s, mosi_s, ss_s;
    logic        rise, fall, sdi, sdo, abort;
    logic [7:0]  rx_next;
    logic [SYNC_N-1:0] sck_sync, mosi_sync, ss_sync;

    assign is_m   = ctrl.on && ctrl.master;
    assign is_s   = ctrl.on && !ctrl.master;
    assign modf   = is_m && !ss_s;
    assign stop_m = modf || !is_m;
    assign busy   = is_m ? m_busy : (is_s && !ss_s);

    // Two-stage synchronisers for the slave-side pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync  <= '0;
            mosi_sync <= '0;
            ss_sync   <= '1;
            sck_p     <= 1'b0;
        end else begin
            sck_sync  <= {sck_sync[SYNC_N-2:0], sck_i};
            mosi_sync <= {mosi_sync[SYNC_N-2:0], mosi_i};
            ss_sync   <= {ss_sync[SYNC_N-2:0], ss_n_i};
            sck_p     <= sck_s;
        end
    end
    assign sck_s  = sck_sync[SYNC_N-1];
    assign mosi_s = mosi_sync[SYNC_N-1];
    assign ss_s   = ss_sync[SYNC_N-1];

    // Master busy state.
    always_ff @(posedge clk) begin
        if (!rst_n)              m_busy <= 1'b0;
        else if (stop_m)         m_busy <= 1'b0;
        else if (start)          m_busy <= 1'b1;
        else if (done)           m_busy <= 1'b0;
    end

    // Master serial clock, idle low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sck_q <= 1'b0;
        else if (!m_busy || stop_m)  sck_q <= 1'b0;
        else if (tick)               sck_q <= ~sck_q;
    end

    assign rise  = is_m ? (tick && !sck_q) : (is_s && !ss_s && sck_s && !sck_p);
    assign fall  = is_m ? (tick && sck_q)  : (is_s && !ss_s && !sck_s && sck_p);
    assign sdi   = is_m ? miso_i : mosi_s;
    assign abort = is_m ? modf : (!is_s || ss_s);

    spi_rate_gen #(.HALF_MAX(HALF_MAX)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(ctrl.rate),
        .dbl(dbl), .tick(tick)
    );

    spi_shift_engine #(.W(BYTE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .load(start), .load_data(reg_wdata),
        .abort(abort), .rise(rise), .fall(fall), .sdi(sdi), .sdo(sdo),
        .done(done), .rx_next(rx_next)
    );

    spi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd_en(reg_rd),
        .wr_en(reg_wr), .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .done(done), .modf(modf), .rx_byte(rx_next), .irq_ack(irq_ack),
        .ctrl(ctrl), .dbl(dbl), .start(start), .irq(irq)
    );

    assign sck_o   = sck_q;
    assign sck_oe  = is_m;
    assign mosi_o  = sdo;
    assign mosi_oe = is_m;
    assign miso_o  = sdo;
    assign miso_oe = is_s && !ss_s;

    // R3
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_busy |-> !sck_q);
    // R10
    miso_slave_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !ctrl.master);
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, irq_ack = 1'b0;
    logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

    int total = 0, bad = 0;
    logic [7:0] mdl_tx = '0, mdl_rx = '0;
    int mdl_idx = 0;

    always #4 clk = ~clk;

    spi_port u0 (.*);

    // Slave model for master-mode tests.
    assign miso_i = (mdl_idx < 8) ? mdl_tx[7 - mdl_idx] : 1'b0;
    always @(negedge sck_o) mdl_idx = mdl_idx + 1;
    always @(posedge sck_o) mdl_rx = {mdl_rx[6:0], mosi_o};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        do begin @(posedge clk); #1 k++; end while (!irq && k < 4000);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd0, v); chk("R1 data", v, 8'h00);
        chk("R1 pins", {sck_o, sck_oe, mosi_oe, miso_oe}, 4'b0000);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R9 reserved zero", v, 8'h01);
        wr(2'd1, 8'h00); rd(2'd1, v); chk("R9 bit0 clear", v, 8'h00);
    endtask

    task automatic t_master(input logic [1:0] rate, input logic d, input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] v; int k; int n;
        n = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
        if (d) n = n / 2;
        wr(2'd2, {3'b000, rate, 3'b111});
        wr(2'd1, {7'b0, d});
        mdl_tx = rx; mdl_idx = 0;
        wr(2'd0, tx);
        wait_irq(k);
        chk("R3 transfer cycles", k, 8 * n);
        chk("R2 mosi byte", mdl_rx, tx);
        chk("R4 irq", irq, 1'b1);
        rd(2'd1, v); chk("R4 status", v, {7'b1000000, d});
        rd(2'd0, v); chk("R2 received", v, rx);
        rd(2'd1, v); chk("R6 cleared", v, {7'b0, d});
    endtask

    task automatic t_collision();
        logic [7:0] v, prev; int k;
        wr(2'd2, 8'h0F); wr(2'd1, 8'h00);
        rd(2'd0, prev);
        mdl_tx = 8'hE7; mdl_idx = 0;
        wr(2'd0, 8'h81);
        repeat (20) @(posedge clk);
        rd(2'd0, v); chk("R2 buffer not live", v, prev);
        wr(2'd0, 8'hFF);
        rd(2'd1, v); chk("R5 wcol set", v, 8'h40);
        wait_irq(k);
        chk("R5 byte unchanged", mdl_rx, 8'h81);
        rd(2'd0, v); chk("R5 rx ok", v, 8'hE7);
        rd(2'd1, v); chk("R6 spif kept without armed read", v, 8'h80);
        rd(2'd0, v);
        rd(2'd1, v); chk("R6 both cleared", v, 8'h00);
    endtask

    task automatic t_ack();
        logic [7:0] v; int k;
        wr(2'd2, 8'h07);
        mdl_tx = 8'h11; mdl_idx = 0;
        wr(2'd0, 8'h22);
        wait_irq(k);
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1 irq_ack = 1'b0;
        chk("R7 irq low", irq, 1'b0);
        rd(2'd1, v); chk("R7 status", v, 8'h00);
    endtask

    task automatic t_modf();
        logic [7:0] v;
        wr(2'd2, 8'h1F);
        mdl_tx = 8'h00; mdl_idx = 0;
        wr(2'd0, 8'h55);
        repeat (30) @(posedge clk);
        @(negedge clk) ss_n_i = 1'b0;
        repeat (4) @(posedge clk);
        #1 chk("R8 sck stopped", {sck_oe, sck_o}, 2'b00);
        rd(2'd2, v); chk("R8 master cleared", v, 8'h1D);
        rd(2'd1, v); chk("R8 spif", v, 8'h80);
        rd(2'd0, v);
        @(negedge clk) ss_n_i = 1'b1;
        repeat (4) @(posedge clk);
        rd(2'd1, v); chk("R6 modf cleared", v, 8'h00);
    endtask

    task automatic t_slave();
        logic [7:0] v, cap, txb;
        txb = 8'h5A; cap = '0;
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h96);
        #1 chk("R10 miso off", miso_oe, 1'b0);
        @(negedge clk) ss_n_i = 1'b0;
        repeat (4) @(posedge clk);
        #1 chk("R10 miso on", miso_oe, 1'b1);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) begin sck_i = 1'b0; mosi_i = txb[i]; end
            repeat (8) @(negedge clk);
            sck_i = 1'b1; cap = {cap[6:0], miso_o};
            repeat (8) @(negedge clk);
        end
        sck_i = 1'b0;
        repeat (6) @(posedge clk);
        #1 chk("R10 done irq", irq, 1'b1);
        chk("R10 miso byte", cap, 8'h96);
        @(negedge clk) ss_n_i = 1'b1;
        repeat (4) @(posedge clk);
        rd(2'd1, v); chk("R10 status", v, 8'h80);
        rd(2'd0, v); chk("R10 received", v, 8'h5A);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_master(2'd0, 1'b1, 8'hA5, 8'h3C);
        t_master(2'd0, 1'b0, 8'h6B, 8'hD2);
        t_master(2'd1, 1'b0, 8'h0F, 8'hF1);
        t_master(2'd3, 1'b1, 8'hC3, 8'h18);
        t_collision();
        t_ack();
        t_modf();
        t_slave();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule